// File: doc/BRIEF.md
# Four-Lane 7:1 Deserializing Receiver

This block takes four serial data lanes and one forwarded-clock lane, each sampled once per cycle of an already phase-aligned bit clock running at seven times the frame rate. Every frame carries seven bit slots per lane. The receiver rebuilds the 28-bit parallel word and presents it with a recovered frame-rate strobe, whose rising edge marks a stable, valid word.

The frame boundary is not known in advance. The receiver tracks the last seven forwarded-clock samples and looks for the fixed frame marker 1100011. The slot-0 sample comes first in that marker, and it occurs at only one rotation. A state machine moves between four named states:
- `AL_OFF`: power-down.
- `AL_HUNT`: searching for the marker at any offset.
- `AL_CONFIRM`: the marker was seen once, and the receiver waits exactly one frame for it to appear again.
- `AL_LOCK`: aligned.

The transitions are:
- `AL_HUNT` to `AL_CONFIRM` when the marker is seen.
- `AL_CONFIRM` to `AL_LOCK` when the marker is found again at the next frame end.
- `AL_CONFIRM` or `AL_LOCK` back to `AL_HUNT` when the marker is missing at a frame end.
- Any state to `AL_OFF` while power-down is high.
- `AL_OFF` to `AL_HUNT` on release of power-down.
- Reset enters `AL_HUNT`.

A power-down input clears the state and forces all outputs low.

Top module: `rx7_deser_top`

## Requirements
- R1: Output bit 7k+i carries the sample that lane k delivered in slot i of a frame. Slot 0 is the first sample of a frame, so a word sent on the lanes comes back unchanged.
- R2: A frame ends where the last seven forwarded-clock samples, oldest first, read 1,1,0,0,0,1,1. `locked` rises on the bit-clock edge that finds this marker a second time, exactly seven cycles after the first find.
- R3: If the marker is missing at an expected frame end, `locked` and `word_valid` fall on that edge, and the search restarts from the next sample.
- R4: `word_out` changes only on a frame-end edge while locked. At that edge it takes the word that completed one frame earlier, and otherwise it holds.
- R5: `word_valid` stays low until lock. It rises on the first frame end after lock, carrying the second marked frame.
- R6: While locked, `strobe_out` is low for the three bit cycles after each frame end and high for the following four. It is low whenever the receiver is not locked, so its rising edge always falls mid-frame with `word_out` stable.
- R7: From the first bit-clock edge that samples `pwr_dn` high, `word_out`, `word_valid`, `strobe_out` and `locked` are all zero, and they stay zero while `pwr_dn` stays high.
- R8: After `pwr_dn` is released, alignment is searched again from scratch, and lock returns once two consecutive marked frames are seen.
- R9: After reset, all outputs are zero and the receiver is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate sampling clock, seven cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Power-down, active high |
| lane_in | input | 4 | One sample per data lane per bit cycle |
| lane_fclk | input | 1 | Sample of the forwarded-clock lane |
| word_out | output | 28 | Rebuilt parallel word |
| word_valid | output | 1 | Word is from an aligned frame |
| strobe_out | output | 1 | Recovered frame clock |
| locked | output | 1 | Frame alignment held |

## Verification
The bench builds the receiver with its default parameters: four lanes, seven slots and the 1100011 marker. With these values one frame is seven bench cycles, so lock, loss of lock and relock each fit within a few dozen cycles. The stream starts three cycles off a frame boundary, which makes the hunt find a non-zero offset. One frame is sent with a broken marker to force loss of lock. Power-down is released in the middle of a frame, so the search after release must realign rather than reuse the old phase.

// File: rtl/rx7_pkg.sv
package rx7_pkg;

    typedef enum logic [1:0] {
        AL_OFF     = 2'd0,
        AL_HUNT    = 2'd1,
        AL_CONFIRM = 2'd2,
        AL_LOCK    = 2'd3
    } al_state_e;

endpackage

// File: rtl/rx7_lane_shifter.sv
module rx7_lane_shifter #(
    parameter int LANES = 4,
    parameter int SLOTS = 7,
    localparam int WIDTH = LANES * SLOTS
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LANES-1:0] lane_in,
    input  logic             lane_fclk,
    output logic [SLOTS-1:0] fclk_hist,
    output logic [WIDTH-1:0] word_asm
);

    always_ff @(posedge clk_bit) begin
        if (!rst_n || clr) begin
            fclk_hist <= '0;
        end else begin
            fclk_hist <= {fclk_hist[SLOTS-2:0], lane_fclk};
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SLOTS-1:0] sh_q;

        always_ff @(posedge clk_bit) begin
            if (!rst_n || clr) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[SLOTS-2:0], lane_in[k]};
            end
        end

        // oldest sample (slot 0) sits at the top of the shifter
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            assign word_asm[k*SLOTS + i] = sh_q[SLOTS-1-i];
        end
    end

endmodule

// File: rtl/rx7_frame_aligner.sv
module rx7_frame_aligner
    import rx7_pkg::*;
#(
    parameter int              SLOTS   = 7,
    parameter logic [SLOTS-1:0] MARKER = 7'b1100011,
    localparam int             CW      = $clog2(SLOTS)
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [SLOTS-1:0] fclk_hist,
    output al_state_e        st_q,
    output al_state_e        st_nxt,
    output logic [CW-1:0]    cnt_nxt,
    output logic             frame_good,
    output logic             frame_bad
);

    localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);

    logic [CW-1:0] cnt_q;
    logic          marker_hit;
    logic          frame_end;
    logic          tracking;

    assign marker_hit = (fclk_hist == MARKER);
    assign frame_end  = (cnt_q == LAST_SLOT);
    assign tracking   = (st_q == AL_CONFIRM) || (st_q == AL_LOCK);
    assign frame_good = !pwr_dn && tracking && frame_end && marker_hit;
    assign frame_bad  = !pwr_dn && tracking && frame_end && !marker_hit;

    // state register
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            st_q  <= AL_HUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // next-state logic
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = frame_end ? '0 : cnt_q + 1'b1;
        if (pwr_dn) begin
            st_nxt  = AL_OFF;
            cnt_nxt = '0;
        end else begin
            unique case (st_q)
                AL_OFF: begin
                    st_nxt  = AL_HUNT;
                    cnt_nxt = '0;
                end
                AL_HUNT: begin
                    cnt_nxt = '0;
                    if (marker_hit) begin
                        st_nxt = AL_CONFIRM;
                    end
                end
                AL_CONFIRM, AL_LOCK: begin
                    if (frame_end) begin
                        st_nxt = marker_hit ? AL_LOCK : AL_HUNT;
                    end
                end
            endcase
        end
    end

    AST_LOCK_VIA_CONFIRM: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (st_q == AL_HUNT || st_q == AL_OFF) |=> (st_q != AL_LOCK)); // R2

    AST_DROP_ON_MISS: assert property (@(posedge clk_bit) disable iff (!rst_n)
        frame_bad |=> (st_q == AL_HUNT)); // R3

    AST_PD_TO_OFF: assert property (@(posedge clk_bit) disable iff (!rst_n)
        pwr_dn |=> (st_q == AL_OFF)); // R7

    AST_RELEASE_HUNTS: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (st_q == AL_OFF && !pwr_dn) |=> (st_q == AL_HUNT)); // R8

endmodule

// File: rtl/rx7_word_assembler.sv
module rx7_word_assembler
    import rx7_pkg::*;
#(
    parameter int  WIDTH       = 28,
    parameter int  SLOTS       = 7,
    localparam int CW          = $clog2(SLOTS),
    localparam int STROBE_RISE = SLOTS / 2
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [WIDTH-1:0] word_asm,
    input  logic             frame_good,
    input  logic             frame_bad,
    input  al_state_e        st_q,
    input  al_state_e        st_nxt,
    input  logic [CW-1:0]    cnt_nxt,
    output logic [WIDTH-1:0] word_out,
    output logic             word_valid,
    output logic             strobe_out
);

    logic [WIDTH-1:0] stage_q;
    logic             stage_ok_q;

    // output process
    always_ff @(posedge clk_bit) begin
        if (!rst_n || pwr_dn) begin
            stage_q    <= '0;
            stage_ok_q <= 1'b0;
            word_out   <= '0;
            word_valid <= 1'b0;
            strobe_out <= 1'b0;
        end else begin
            if (frame_good) begin
                stage_q    <= word_asm;
                stage_ok_q <= 1'b1;
                if (st_q == AL_LOCK) begin
                    word_out   <= stage_q;
                    word_valid <= stage_ok_q;
                end
            end else if (frame_bad) begin
                stage_ok_q <= 1'b0;
                word_valid <= 1'b0;
            end
            strobe_out <= (st_nxt == AL_LOCK) && (cnt_nxt >= CW'(STROBE_RISE));
        end
    end

    AST_PD_OUT_LOW: assert property (@(posedge clk_bit) disable iff (!rst_n)
        pwr_dn |=> (word_out == '0 && !word_valid && !strobe_out)); // R7

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_bit) disable iff (!rst_n)
        word_valid |-> (st_q == AL_LOCK)); // R5

    AST_WORD_HOLD: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!frame_good && !pwr_dn) |=> $stable(word_out)); // R4

    AST_STROBE_LOCKED: assert property (@(posedge clk_bit) disable iff (!rst_n)
        strobe_out |-> (st_q == AL_LOCK)); // R6

endmodule

// File: rtl/rx7_deser_top.sv
module rx7_deser_top
    import rx7_pkg::*;
#(
    parameter int               LANES  = 4,
    parameter int               SLOTS  = 7,
    parameter logic [SLOTS-1:0] MARKER = 7'b1100011,
    localparam int              WIDTH  = LANES * SLOTS,
    localparam int              CW     = $clog2(SLOTS)
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [LANES-1:0] lane_in,
    input  logic             lane_fclk,
    output logic [WIDTH-1:0] word_out,
    output logic             word_valid,
    output logic             strobe_out,
    output logic             locked
);

    logic [SLOTS-1:0] fclk_hist;
    logic [WIDTH-1:0] word_asm;
    al_state_e        st_q;
    al_state_e        st_nxt;
    logic [CW-1:0]    cnt_nxt;
    logic             frame_good;
    logic             frame_bad;

    rx7_lane_shifter #(.LANES(LANES), .SLOTS(SLOTS)) u_shift (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .clr       (pwr_dn),
        .lane_in   (lane_in),
        .lane_fclk (lane_fclk),
        .fclk_hist (fclk_hist),
        .word_asm  (word_asm)
    );

    rx7_frame_aligner #(.SLOTS(SLOTS), .MARKER(MARKER)) u_align (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .fclk_hist  (fclk_hist),
        .st_q       (st_q),
        .st_nxt     (st_nxt),
        .cnt_nxt    (cnt_nxt),
        .frame_good (frame_good),
        .frame_bad  (frame_bad)
    );

    rx7_word_assembler #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_asm (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .word_asm   (word_asm),
        .frame_good (frame_good),
        .frame_bad  (frame_bad),
        .st_q       (st_q),
        .st_nxt     (st_nxt),
        .cnt_nxt    (cnt_nxt),
        .word_out   (word_out),
        .word_valid (word_valid),
        .strobe_out (strobe_out)
    );

    assign locked = (st_q == AL_LOCK);

endmodule

// File: tb/rx7_deser_top_tb.sv
module rx7_deser_top_tb_top;

    localparam int NL = 4;
    localparam int NS = 7;
    localparam int NW = NL * NS;

    logic          clk_bit = 1'b0;
    logic          rst_n;
    logic          pwr_dn;
    logic [NL-1:0] lane_in;
    logic          lane_fclk;
    logic [NW-1:0] word_out;
    logic          word_valid;
    logic          strobe_out;
    logic          locked;

    rx7_deser_top dut_i (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .lane_in    (lane_in),
        .lane_fclk  (lane_fclk),
        .word_out   (word_out),
        .word_valid (word_valid),
        .strobe_out (strobe_out),
        .locked     (locked)
    );

    always #5 clk_bit = ~clk_bit;

    // marker bits listed slot 0 first
    bit     mark [NS] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    int     n_checks = 0;
    int     n_errors = 0;
    bit     finished = 0;
    int     pd_left  = 0;
    logic [NW-1:0] sent_q [$];

    task automatic chk(input bit ok, input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_state;   // 0 off, 1 hunt, 2 confirm, 3 lock
    int            m_cnt;
    logic [NW-1:0] m_stage, m_word, m_asm;
    bit            m_stage_ok, m_valid, m_strobe, m_hit, m_pd;
    bit            m_started = 0;
    logic [NL-1:0] lq [$];
    bit            cq [$];

    always @(posedge clk_bit) begin
        m_started = 1;
        m_pd      = 0;
        if (!rst_n || pwr_dn) begin
            m_state    = rst_n ? 0 : 1;
            m_pd       = rst_n;
            m_cnt      = 0;
            m_stage    = '0;
            m_word     = '0;
            m_stage_ok = 0;
            m_valid    = 0;
            m_strobe   = 0;
            lq.delete();
            cq.delete();
        end else begin
            m_hit = (cq.size() == NS);
            if (m_hit) begin
                for (int i = 0; i < NS; i++) if (cq[i] != mark[i]) m_hit = 0;
                for (int k = 0; k < NL; k++)
                    for (int i = 0; i < NS; i++) m_asm[k*NS+i] = lq[i][k];
            end
            case (m_state)
                0: begin m_state = 1; m_cnt = 0; end
                1: begin m_cnt = 0; if (m_hit) m_state = 2; end
                default: begin
                    if (m_cnt == NS-1) begin
                        m_cnt = 0;
                        if (m_hit) begin
                            if (m_state == 3) begin
                                m_word  = m_stage;
                                m_valid = m_stage_ok;
                            end
                            m_stage    = m_asm;
                            m_stage_ok = 1;
                            m_state    = 3;
                        end else begin
                            m_state    = 1;
                            m_valid    = 0;
                            m_stage_ok = 0;
                        end
                    end else begin
                        m_cnt++;
                    end
                end
            endcase
            m_strobe = (m_state == 3) && (m_cnt >= 3);
            lq.push_back(lane_in);
            cq.push_back(lane_fclk);
            if (lq.size() > NS) begin
                void'(lq.pop_front());
                void'(cq.pop_front());
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    bit prev_strobe = 0;
    always @(negedge clk_bit) begin
        if (m_started && !finished) begin
            chk(word_out == m_word, "R4 word_out", word_out, m_word);
            chk(word_valid == m_valid, "R5 word_valid", NW'(word_valid), NW'(m_valid));
            chk(strobe_out == m_strobe, "R6 strobe_out", NW'(strobe_out), NW'(m_strobe));
            chk(locked == (m_state == 3), "R2 locked", NW'(locked), NW'(m_state == 3));
            if (m_pd)
                chk(word_out == '0 && !word_valid && !strobe_out && !locked, "R7 outputs low in power-down",
                    {word_out[NW-4:0], word_valid, strobe_out, locked}, '0);
            if (strobe_out && !prev_strobe && word_valid) begin
                bit found = 0;
                for (int j = 0; j < sent_q.size(); j++) if (sent_q[j] == word_out) found = 1;
                chk(found, "R1 word matches a sent word", word_out, sent_q.size() > 0 ? sent_q[sent_q.size()-1] : '0);
            end
            prev_strobe = strobe_out;
        end
    end

    // ---------------- stimulus: transmitter side ----------------
    task automatic drive_slot(input logic [NL-1:0] d, input bit c);
        @(negedge clk_bit);
        pwr_dn = (pd_left > 0);
        if (pd_left > 0) pd_left--;
        lane_in   = d;
        lane_fclk = c;
    endtask

    task automatic send_frame(input bit bad_marker);
        logic [NW-1:0] w;
        w = NW'($urandom());
        sent_q.push_back(w);
        if (sent_q.size() > 4) void'(sent_q.pop_front());
        for (int s = 0; s < NS; s++) begin
            logic [NL-1:0] d;
            for (int k = 0; k < NL; k++) d[k] = w[k*NS+s];
            drive_slot(d, bad_marker ? 1'b0 : mark[s]);
        end
    endtask

    initial begin
        rst_n = 0; pwr_dn = 0; lane_in = '0; lane_fclk = 0;
        repeat (4) @(negedge clk_bit);
        #1;
        chk(word_out == '0 && !word_valid && !strobe_out && !locked, "R9 reset state",
            {word_out[NW-4:0], word_valid, strobe_out, locked}, '0);
        @(negedge clk_bit);
        rst_n = 1;
        // start three cycles off the frame grid
        for (int j = 0; j < 3; j++) drive_slot(NL'($urandom()), 1'b0);
        for (int f = 0; f < 20; f++) send_frame(0);
        #1;
        chk(locked, "R2 lock after marked frames", NW'(locked), NW'(1));
        chk(word_valid, "R5 valid once locked", NW'(word_valid), NW'(1));
        // broken marker forces loss of lock
        send_frame(1);
        send_frame(0);
        #1;
        chk(!locked && !word_valid, "R3 lock dropped on missing marker",
            NW'({locked, word_valid}), NW'(0));
        for (int f = 0; f < 4; f++) send_frame(0);
        #1;
        chk(locked, "R3 relock after search", NW'(locked), NW'(1));
        // power-down released mid-frame
        pd_left = 12;
        for (int f = 0; f < 2; f++) send_frame(0);
        #1;
        chk(!locked, "R8 hunting after release", NW'(locked), NW'(0));
        for (int f = 0; f < 4; f++) send_frame(0);
        #1;
        chk(locked && word_valid, "R8 lock regained after release",
            NW'({locked, word_valid}), NW'(3));
        for (int f = 0; f < 10; f++) send_frame(0);
        @(negedge clk_bit);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_bit);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule